// File: doc/BRIEF.md
# Interrupt Controller Register Decoder

This block is the bus-facing register front end of a platform interrupt controller. A 32-bit APB-style slave port reaches four address windows: one word per interrupt source holding its priority, a packed read-only view of the pending bits, a block of enable words per target context, and a per-context pair made of a threshold register and a claim/complete register. The priority arbiter is a separate block. This decoder reads the arbiter's state through flat input vectors and changes that state through single-cycle write strobes with their data.

Reading the claim register has a side effect. It raises a claim strobe toward the arbiter and returns the source ID that the arbiter grants in the same cycle. Writing a source ID to the same register raises a completion strobe. Writes are filtered by window:

- pending is read-only;
- a priority write keeps only the low three data bits;
- a threshold write above the maximum priority is dropped.

Misaligned, unmapped and invalid offsets read as zero, change nothing and flag a slave error. The port never inserts wait states.

Source IDs run from 1 to NSRC. ID 0 means "no interrupt". The window bases, the two strides, the number of sources, the number of contexts and the maximum priority are all parameters.

Top module: `irq_reg_front`

## Requirements
- R1: `pready` is always 1, so every transfer completes in its first access cycle (`psel` and `penable` both high).
- R2: An access whose `paddr[1:0]` is not 00 reads 0, raises no strobe and sets `pslverr` for that access.
- R3: The word at PRIO_BASE+4k (k < NSRC) reads the priority of source k+1 in bits [2:0], with all other bits 0. A write to it pulses `prio_we` with `prio_src` = k+1 and `prio_data` = `pwdata[2:0]`.
- R4: The word at PEND_BASE+4w reads bit b as the pending flag of source 32w+b. Bit 0 of word 0 and bits above source NSRC read 0. A write to this window raises no strobe and no error.
- R5: In the enable window, the context is (offset / EN_STRIDE) and the word is (offset mod EN_STRIDE)/4. Words below ceil((NSRC+1)/32) read bit b as the enable of source 32w+b for that context. A write to such a word pulses `en_we` with `tgt_ctx`, `en_word` and the full `pwdata`. Words at or above that count are invalid.
- R6: Offset 0 of context c's block (CTX_BASE + c·CTX_STRIDE) reads that context's threshold. A write pulses `thr_we` only when `pwdata` ≤ MAXPRIO. A larger value is dropped without an error.
- R7: A read at offset 4 of a context block pulses `claim_stb` with `tgt_ctx` = c and returns `claim_id_i` on `prdata` in the same cycle.
- R8: `claim_stb` and every other strobe fires at most once per transfer, in the first access cycle, even if the access phase is held longer.
- R9: A write at offset 4 of a context block pulses `cmpl_stb` with `cmpl_id` = `pwdata` when 1 ≤ `pwdata` ≤ NSRC. Any other value is dropped without an error.
- R10: An aligned access that falls outside every window, at a context-block offset other than 0 or 4, or on an invalid enable word reads 0, raises no strobe and sets `pslverr` for exactly one cycle.
- R11: While `presetn` is low, no strobe and no `pslverr` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | AW | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access cycle of a read |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Error for a bad access |
| src_prio_i | input | NSRC·PW | Source priorities; slice s holds source s+1 |
| pend_i | input | NSRC | Pending flags; bit s is source s+1 |
| en_i | input | NCTX·NSRC | Enables; slice c is context c, bit s is source s+1 |
| thr_i | input | NCTX·PW | Thresholds; slice c is context c |
| claim_id_i | input | IDW | Source ID granted by the arbiter for a claim this cycle |
| prio_we | output | 1 | Priority write strobe |
| prio_src | output | IDW | Source ID addressed by the priority write |
| prio_data | output | PW | Masked priority value |
| en_we | output | 1 | Enable word write strobe |
| en_word | output | WW | Enable word index |
| en_data | output | 32 | Enable word value |
| thr_we | output | 1 | Threshold write strobe |
| thr_data | output | PW | Threshold value |
| claim_stb | output | 1 | Claim request strobe |
| cmpl_stb | output | 1 | Completion strobe |
| cmpl_id | output | IDW | Completed source ID |
| tgt_ctx | output | CW | Context addressed by an enable, threshold, claim or completion access |

## Verification
The assertions assume that the master follows the APB transfer shape: every transfer has a setup cycle with `penable` low before its access cycle. Under that assumption, one claim strobe or one error pulse can never be followed by another in the next cycle. The bench drives every transfer through one task that always inserts a setup cycle. The only deliberate break of the shape is a single directed test that holds the access phase for three cycles, and that test shows the claim strobe still fires once. The assertions also assume that the arbiter inputs are stable within an access. The bench holds those inputs constant for the whole run, so every expected read value is a fixed pattern.

// File: rtl/irq_reg_front.sv
module irq_reg_front #(
  parameter int AW         = 16,
  parameter int NSRC       = 40,
  parameter int NCTX       = 2,
  parameter int PW         = 3,
  parameter int MAXPRIO    = 6,
  parameter logic [AW-1:0] PRIO_BASE = 16'h0000,
  parameter logic [AW-1:0] PEND_BASE = 16'h1000,
  parameter logic [AW-1:0] EN_BASE   = 16'h2000,
  parameter int EN_STRIDE  = 128,
  parameter logic [AW-1:0] CTX_BASE  = 16'h4000,
  parameter int CTX_STRIDE = 4096,
  localparam int NW  = (NSRC + 32) / 32,
  localparam int IDW = $clog2(NSRC + 1),
  localparam int CW  = (NCTX > 1) ? $clog2(NCTX) : 1,
  localparam int WW  = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic                 pclk,
  input  logic                 presetn,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [AW-1:0]        paddr,
  input  logic [31:0]          pwdata,
  output logic [31:0]          prdata,
  output logic                 pready,
  output logic                 pslverr,
  input  logic [NSRC*PW-1:0]   src_prio_i,
  input  logic [NSRC-1:0]      pend_i,
  input  logic [NCTX*NSRC-1:0] en_i,
  input  logic [NCTX*PW-1:0]   thr_i,
  input  logic [IDW-1:0]       claim_id_i,
  output logic                 prio_we,
  output logic [IDW-1:0]       prio_src,
  output logic [PW-1:0]        prio_data,
  output logic                 en_we,
  output logic [WW-1:0]        en_word,
  output logic [31:0]          en_data,
  output logic                 thr_we,
  output logic [PW-1:0]        thr_data,
  output logic                 claim_stb,
  output logic                 cmpl_stb,
  output logic [IDW-1:0]       cmpl_id,
  output logic [CW-1:0]        tgt_ctx
);
  localparam int ELG = $clog2(EN_STRIDE);
  localparam int CLG = $clog2(CTX_STRIDE);
  localparam logic [AW-1:0] PRIO_SZ = AW'(4 * NSRC);
  localparam logic [AW-1:0] PEND_SZ = AW'(4 * NW);
  localparam logic [AW-1:0] EN_SZ   = AW'(NCTX * EN_STRIDE);
  localparam logic [AW-1:0] CTX_SZ  = AW'(NCTX * CTX_STRIDE);

  logic acc, acc_q, first, wr, rd;
  assign acc   = psel & penable;
  assign first = presetn & acc & ~acc_q;
  assign wr    = first & pwrite;
  assign rd    = first & ~pwrite;

  always_ff @(posedge pclk or negedge presetn)
    if (!presetn) acc_q <= 1'b0;
    else          acc_q <= acc;

  logic [AW-1:0] o_pr, o_pd, o_en, o_cx;
  assign o_pr = paddr - PRIO_BASE;
  assign o_pd = paddr - PEND_BASE;
  assign o_en = paddr - EN_BASE;
  assign o_cx = paddr - CTX_BASE;

  logic aligned;
  assign aligned = (paddr[1:0] == 2'b00);

  logic [IDW-1:0]   pr_i;
  logic [WW-1:0]    pd_w;
  logic [CW-1:0]    en_c, cx_c;
  logic [ELG-3:0]   en_wf;
  logic [CLG-1:0]   cx_lo;
  assign pr_i  = IDW'(o_pr >> 2);
  assign pd_w  = WW'(o_pd >> 2);
  assign en_c  = CW'(o_en >> ELG);
  assign en_wf = (ELG-2)'(o_en >> 2);
  assign en_word = WW'(en_wf);
  assign cx_c  = CW'(o_cx >> CLG);
  assign cx_lo = CLG'(o_cx);

  logic h_pr, h_pd, h_en, h_thr, h_clm, valid;
  assign h_pr  = aligned & (o_pr < PRIO_SZ);
  assign h_pd  = aligned & (o_pd < PEND_SZ);
  assign h_en  = aligned & (o_en < EN_SZ) & (en_wf < (ELG-2)'(NW));
  assign h_thr = aligned & (o_cx < CTX_SZ) & (cx_lo == CLG'(0));
  assign h_clm = aligned & (o_cx < CTX_SZ) & (cx_lo == CLG'(4));
  assign valid = h_pr | h_pd | h_en | h_thr | h_clm;

  logic [NW*32-1:0]      pend_ext;
  logic [NCTX*NW*32-1:0] en_ext;
  assign pend_ext = (NW*32)'({pend_i, 1'b0});
  for (genvar c = 0; c < NCTX; c++) begin : g_en
    assign en_ext[c*NW*32 +: NW*32] = (NW*32)'({en_i[c*NSRC +: NSRC], 1'b0});
  end

  logic [31:0] rdv;
  always_comb begin
    rdv = '0;
    if (h_pr) begin
      for (int s = 0; s < NSRC; s++)
        if (pr_i == IDW'(s)) rdv = 32'(src_prio_i[s*PW +: PW]);
    end else if (h_pd) begin
      for (int w = 0; w < NW; w++)
        if (pd_w == WW'(w)) rdv = pend_ext[w*32 +: 32];
    end else if (h_en) begin
      for (int c = 0; c < NCTX; c++)
        for (int w = 0; w < NW; w++)
          if (en_c == CW'(c) && en_word == WW'(w))
            rdv = en_ext[c*NW*32 + w*32 +: 32];
    end else if (h_thr) begin
      for (int c = 0; c < NCTX; c++)
        if (cx_c == CW'(c)) rdv = 32'(thr_i[c*PW +: PW]);
    end else if (h_clm) begin
      rdv = 32'(claim_id_i);
    end
  end

  assign prdata    = rd ? rdv : 32'd0;
  assign pready    = 1'b1;
  assign pslverr   = first & ~valid;

  assign prio_we   = wr & h_pr;
  assign prio_src  = pr_i + IDW'(1);
  assign prio_data = pwdata[PW-1:0];
  assign en_we     = wr & h_en;
  assign en_data   = pwdata;
  assign thr_we    = wr & h_thr & (pwdata <= 32'(MAXPRIO));
  assign thr_data  = pwdata[PW-1:0];
  assign claim_stb = rd & h_clm;
  assign cmpl_stb  = wr & h_clm & (pwdata != 32'd0) & (pwdata <= 32'(NSRC));
  assign cmpl_id   = IDW'(pwdata);
  assign tgt_ctx   = (h_thr | h_clm) ? cx_c : en_c;
endmodule

module irq_reg_front_chk #(
  parameter int AW      = 16,
  parameter int NSRC    = 40,
  parameter int MAXPRIO = 6
) (
  input logic          pclk,
  input logic          presetn,
  input logic          psel,
  input logic          penable,
  input logic [AW-1:0] paddr,
  input logic [31:0]   pwdata,
  input logic [31:0]   prdata,
  input logic          pready,
  input logic          pslverr,
  input logic          prio_we,
  input logic          en_we,
  input logic          thr_we,
  input logic          claim_stb,
  input logic          cmpl_stb
);
  logic any_stb;
  assign any_stb = prio_we | en_we | thr_we | claim_stb | cmpl_stb;

  // R1
  pready_high_chk: assert property (@(posedge pclk) disable iff (!presetn) pready);

  // R2
  misalign_quiet_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && paddr[1:0] != 2'b00) |-> (!any_stb && prdata == 32'd0));

  // R6
  thr_range_chk: assert property (@(posedge pclk) disable iff (!presetn)
    thr_we |-> (pwdata <= 32'(MAXPRIO)));

  // R8
  claim_once_chk: assert property (@(posedge pclk) disable iff (!presetn)
    claim_stb |=> !claim_stb);

  // R8
  strobe_single_chk: assert property (@(posedge pclk) disable iff (!presetn)
    $onehot0({prio_we, en_we, thr_we, claim_stb, cmpl_stb}));

  // R9
  cmpl_range_chk: assert property (@(posedge pclk) disable iff (!presetn)
    cmpl_stb |-> (pwdata != 32'd0 && pwdata <= 32'(NSRC)));

  // R10
  err_pulse_chk: assert property (@(posedge pclk) disable iff (!presetn)
    pslverr |=> !pslverr);

  // R10
  err_quiet_chk: assert property (@(posedge pclk) disable iff (!presetn)
    pslverr |-> (!any_stb && prdata == 32'd0));

  // R11
  always_comb begin
    if (!presetn) begin
      reset_quiet_chk: assert (!any_stb && !pslverr);
    end
  end
endmodule

bind irq_reg_front irq_reg_front_chk #(.AW(AW), .NSRC(NSRC), .MAXPRIO(MAXPRIO)) u_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .paddr(paddr),
  .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
  .prio_we(prio_we), .en_we(en_we), .thr_we(thr_we), .claim_stb(claim_stb),
  .cmpl_stb(cmpl_stb)
);

// File: tb/tb_irq_reg_front.sv
`timescale 1ns/1ps
module tb_irq_reg_front;
  localparam int NSRC = 40, NCTX = 2, PW = 3;
  localparam int NV = 29;

  logic        pclk = 1'b0, presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [15:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [NSRC*PW-1:0]   src_prio_i;
  logic [NSRC-1:0]      pend_i;
  logic [NCTX*NSRC-1:0] en_i;
  logic [NCTX*PW-1:0]   thr_i;
  logic [5:0]  claim_id_i;
  logic        prio_we, en_we, thr_we, claim_stb, cmpl_stb;
  logic [5:0]  prio_src, cmpl_id;
  logic [2:0]  prio_data, thr_data;
  logic [0:0]  en_word, tgt_ctx;
  logic [31:0] en_data;

  always #4 pclk = ~pclk;

  irq_reg_front dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .src_prio_i(src_prio_i), .pend_i(pend_i), .en_i(en_i), .thr_i(thr_i),
    .claim_id_i(claim_id_i), .prio_we(prio_we), .prio_src(prio_src), .prio_data(prio_data),
    .en_we(en_we), .en_word(en_word), .en_data(en_data), .thr_we(thr_we),
    .thr_data(thr_data), .claim_stb(claim_stb), .cmpl_stb(cmpl_stb), .cmpl_id(cmpl_id),
    .tgt_ctx(tgt_ctx)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [31:0] s_rd;
  logic        s_err, s_rdy;
  logic [4:0]  s_stb;
  logic [5:0]  s_src, s_cid;
  logic [2:0]  s_pd, s_td;
  logic [0:0]  s_ctx, s_word;
  logic [31:0] s_ed;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sample();
    s_rd = prdata; s_err = pslverr; s_rdy = pready;
    s_stb = {prio_we, en_we, thr_we, claim_stb, cmpl_stb};
    s_src = prio_src; s_pd = prio_data; s_td = thr_data; s_cid = cmpl_id;
    s_ctx = tgt_ctx; s_word = en_word; s_ed = en_data;
  endtask

  task automatic xfer(input logic w, input logic [15:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = w; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1;
    #1 sample();
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  // {write, addr, wdata, exp_rdata, exp_err, exp_stb{prio,en,thr,claim,cmpl}, req}
  localparam logic [94:0] VEC [NV] = '{
    {1'b0, 16'h0000, 32'h0,        32'h1,     1'b0, 5'b00000, 8'd3},  // R3 source 1
    {1'b0, 16'h0098, 32'h0,        32'h7,     1'b0, 5'b00000, 8'd3},  // R3 source 39
    {1'b0, 16'h00A0, 32'h0,        32'h0,     1'b1, 5'b00000, 8'd10}, // R10 past last source
    {1'b1, 16'h0008, 32'hFFFFFFFD, 32'h0,     1'b0, 5'b10000, 8'd3},  // R3 write
    {1'b0, 16'h1000, 32'h0,        32'h2,     1'b0, 5'b00000, 8'd4},  // R4 word 0
    {1'b0, 16'h1004, 32'h0,        32'h100,   1'b0, 5'b00000, 8'd4},  // R4 word 1
    {1'b0, 16'h1008, 32'h0,        32'h0,     1'b1, 5'b00000, 8'd10}, // R10
    {1'b1, 16'h1000, 32'hFFFFFFFF, 32'h0,     1'b0, 5'b00000, 8'd4},  // R4 write ignored
    {1'b0, 16'h2000, 32'h0,        32'h1E0,   1'b0, 5'b00000, 8'd5},  // R5 ctx0 w0
    {1'b0, 16'h2004, 32'h0,        32'h1FE,   1'b0, 5'b00000, 8'd5},  // R5 ctx0 w1
    {1'b0, 16'h2080, 32'h0,        32'h2,     1'b0, 5'b00000, 8'd5},  // R5 ctx1 w0
    {1'b0, 16'h2084, 32'h0,        32'h0,     1'b0, 5'b00000, 8'd5},  // R5 ctx1 w1
    {1'b0, 16'h2008, 32'h0,        32'h0,     1'b1, 5'b00000, 8'd5},  // R5 word too high
    {1'b0, 16'h2100, 32'h0,        32'h0,     1'b1, 5'b00000, 8'd10}, // R10 no ctx 2
    {1'b1, 16'h2084, 32'hDEADBEEF, 32'h0,     1'b0, 5'b01000, 8'd5},  // R5 write
    {1'b0, 16'h4000, 32'h0,        32'h3,     1'b0, 5'b00000, 8'd6},  // R6 ctx0
    {1'b0, 16'h5000, 32'h0,        32'h5,     1'b0, 5'b00000, 8'd6},  // R6 ctx1
    {1'b1, 16'h4000, 32'h6,        32'h0,     1'b0, 5'b00100, 8'd6},  // R6 at max
    {1'b1, 16'h4000, 32'h7,        32'h0,     1'b0, 5'b00000, 8'd6},  // R6 above max
    {1'b0, 16'h4008, 32'h0,        32'h0,     1'b1, 5'b00000, 8'd10}, // R10 bad offset
    {1'b0, 16'h5004, 32'h0,        32'h11,    1'b0, 5'b00010, 8'd7},  // R7 claim
    {1'b1, 16'h4004, 32'd40,       32'h0,     1'b0, 5'b00001, 8'd9},  // R9 last ID
    {1'b1, 16'h4004, 32'd0,        32'h0,     1'b0, 5'b00000, 8'd9},  // R9 ID 0
    {1'b1, 16'h4004, 32'd41,       32'h0,     1'b0, 5'b00000, 8'd9},  // R9 too high
    {1'b0, 16'h6000, 32'h0,        32'h0,     1'b1, 5'b00000, 8'd10}, // R10 past ctx
    {1'b0, 16'h3000, 32'h0,        32'h0,     1'b1, 5'b00000, 8'd10}, // R10 gap
    {1'b0, 16'h4002, 32'h0,        32'h0,     1'b1, 5'b00000, 8'd2},  // R2 read
    {1'b1, 16'h0001, 32'h5,        32'h0,     1'b1, 5'b00000, 8'd2},  // R2 write
    {1'b0, 16'h0004, 32'h0,        32'h2,     1'b0, 5'b00000, 8'd3}   // R3 source 2
  };

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", checks, NV);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int s = 1; s <= NSRC; s++) src_prio_i[(s-1)*PW +: PW] = PW'(s % 8);
    pend_i     = 40'h80_0000_0001;
    en_i       = {40'h00_0000_0001, 40'hFF_0000_00F0};
    thr_i      = {3'd5, 3'd3};
    claim_id_i = 6'd17;

    // R11: an access during reset raises nothing
    psel = 1'b1; pwrite = 1'b0; paddr = 16'h5004;
    repeat (2) @(negedge pclk);
    penable = 1'b1;
    #1;
    check("R11 claim in reset", 32'(claim_stb), 32'd0);
    check("R11 err in reset", 32'(pslverr), 32'd0);
    check("R1 ready in reset", 32'(pready), 32'd1);
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
    @(negedge pclk);
    presetn = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i][7:0], i);
      xfer(VEC[i][94], VEC[i][93:78], VEC[i][77:46]);
      check({tag, " rdata"}, s_rd, VEC[i][45:14]);
      check({tag, " err"}, 32'(s_err), 32'(VEC[i][13]));
      check({tag, " strobes"}, 32'(s_stb), 32'(VEC[i][12:8]));
      check("R1 ready", 32'(s_rdy), 32'd1);
    end

    // R3: source ID and masked data of a priority write
    xfer(1'b1, 16'h0008, 32'hFFFFFFFD);
    check("R3 prio_src", 32'(s_src), 32'd3);
    check("R3 prio_data", 32'(s_pd), 32'd5);
    // R5: context, word and data of an enable write
    xfer(1'b1, 16'h2084, 32'hDEADBEEF);
    check("R5 ctx", 32'(s_ctx), 32'd1);
    check("R5 word", 32'(s_word), 32'd1);
    check("R5 data", s_ed, 32'hDEADBEEF);
    // R6: accepted threshold carries its context and value
    xfer(1'b1, 16'h5000, 32'h4);
    check("R6 thr strobe", 32'(s_stb), 32'b00100);
    check("R6 ctx", 32'(s_ctx), 32'd1);
    check("R6 data", 32'(s_td), 32'd4);
    xfer(1'b1, 16'h4000, 32'h8);
    check("R6 thr 8 dropped", 32'(s_stb), 32'd0);
    // R7: claim context
    xfer(1'b0, 16'h4004, 32'h0);
    check("R7 claim ctx", 32'(s_ctx), 32'd0);
    check("R7 claim id", s_rd, 32'd17);
    // R9: completion ID and context
    xfer(1'b1, 16'h5004, 32'd1);
    check("R9 cmpl strobe", 32'(s_stb), 32'b00001);
    check("R9 cmpl id", 32'(s_cid), 32'd1);
    check("R9 cmpl ctx", 32'(s_ctx), 32'd1);

    // R8: access phase held for three cycles claims once
    begin
      int nclaim;
      nclaim = 0;
      @(negedge pclk);
      psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = 16'h5004;
      @(negedge pclk);
      penable = 1'b1;
      for (int k = 0; k < 3; k++) begin
        #1 if (claim_stb) nclaim++;
        @(negedge pclk);
      end
      psel = 1'b0; penable = 1'b0;
      check("R8 claims per held transfer", 32'(nclaim), 32'd1);
    end

    // R10: error lasts one cycle even with a held access
    @(negedge pclk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = 16'h3000;
    @(negedge pclk);
    penable = 1'b1;
    #1 check("R10 err first cycle", 32'(pslverr), 32'd1);
    @(negedge pclk);
    #1 check("R10 err second cycle", 32'(pslverr), 32'd0);
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
    repeat (2) @(negedge pclk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule